// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches a bank of synchronized input pins and turns their level changes into interrupt requests. Each pin keeps a reference level. A pin that moves away from that level gets a pending interrupt. What happens next depends on the pin's capture mode:

- **Follow mode:** the pending flag tracks whether the pin still differs from its reference.
- **Capture mode:** the first changed value is frozen and the flag is held until software reads the pin's port.

A port read reloads every reference of that port from the live pins and clears the port's pending flags. The register decoder provides the per-port read strobe, along with the configuration vectors for direction, capture mode, polarity and mask. In return, the block supplies the value seen by a port read, a per-pin interrupt status, and one enable that pulls a shared active-low interrupt line low.

All outputs are registered. They reflect the inputs present at the previous rising clock edge, and reset is synchronous and active high.

Top module: `pin_change_irq`

## Requirements
- R1: While reset is high, at the next edge every pending flag clears, every status bit reads 0, the interrupt pull enable reads 0, and each reference level loads from its live pin.
- R2: For an input pin in follow mode (capture bit 0), any difference from its reference sets the pin pending. The flag clears again on its own once the pin returns to the reference level.
- R3: For an input pin in capture mode (capture bit 1), the first difference from the reference sets the pin pending and freezes the changed value as the read value. A later return of the pin to the reference neither clears the flag nor alters the frozen value.
- R4: A high read strobe for port p affects pins p*8 to p*8+7, and only those pins. At the next edge it clears their pending flags and reloads their references from the live levels. A captured value is therefore reported once, and afterwards the live level is reported.
- R5: The interrupt pull enable is 1 exactly when at least one status bit is 1; 1 means drive the shared line low.
- R6: A pin's status bit is its pending flag gated by a mask bit of 0. With the mask bit at 1, status reads 0 and the pin does not pull the line. Clearing the mask of an already pending pin raises its status, and setting the mask of a pending pin drops it.
- R7: A pin whose direction bit is 0 (output) has its pending flag cleared and raises no interrupt, while its read value still reports the pin level.
- R8: Switching a pending captured pin to follow mode clears the flag if the pin is back at its reference, and the read value becomes the live level.
- R9: The read value of a pin is its selected value (frozen or live) exclusive-ORed with its polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 16 | Synchronized pin levels |
| capture_en | input | 16 | Per-pin capture mode (1 = hold changed value) |
| invert | input | 16 | Per-pin polarity inversion of the read value |
| dir_in | input | 16 | Per-pin direction (1 = input, 0 = output) |
| irq_mask | input | 16 | Per-pin interrupt mask (1 = suppressed) |
| rd_clr | input | 2 | Per-port read strobe (port p = pins p*8..p*8+7) |
| rd_data | output | 16 | Value returned by a port read |
| irq_status | output | 16 | Per-pin unmasked pending interrupt |
| irq_pull | output | 1 | Open-drain enable for the active-low interrupt line |

## Verification
The hardest case to reach from the ports is a captured pin that has pulsed away from and back to its reference, and that is then acted on before any read. Three actions matter here: a switch to follow mode, an unmask, or a direction change to output. Directed sequences build this case on one pin, step by step, and check each result. A long random run then mixes sparse pin toggles, occasional mode, mask and direction flips, and port reads. This makes pending captured pins common when those changes arrive. Each cycle is compared with a bench model built from the requirements.

// File: rtl/pin_change_pkg.sv
package pin_change_pkg;
  typedef struct packed {
    logic ref_lvl;
    logic pend;
    logic cap;
  } pin_state_t;
endpackage

// File: rtl/pin_change_cell.sv
module pin_change_cell
  import pin_change_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic live,
  input  logic capture,
  input  logic inv,
  input  logic is_input,
  input  logic masked,
  input  logic rd_strobe,
  output logic rd_bit,
  output logic stat_bit,
  output logic stat_next
);
  pin_state_t cur, nxt;

  always_comb begin
    nxt = cur;
    if (!is_input || rd_strobe) begin
      nxt.ref_lvl = live;
      nxt.pend    = 1'b0;
      nxt.cap     = live;
    end else if (capture) begin
      if (!cur.pend) begin
        nxt.cap  = live;
        nxt.pend = (live != cur.ref_lvl);
      end
    end else begin
      nxt.cap  = live;
      nxt.pend = (live != cur.ref_lvl);
    end
  end

  assign stat_next = rst ? 1'b0 : (nxt.pend & ~masked);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur.ref_lvl <= live;
      cur.pend    <= 1'b0;
      cur.cap     <= live;
      rd_bit      <= live ^ inv;
      stat_bit    <= 1'b0;
    end else begin
      cur      <= nxt;
      rd_bit   <= ((capture && nxt.pend) ? nxt.cap : live) ^ inv;
      stat_bit <= nxt.pend & ~masked;
    end
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] stat_next,
  output logic              irq_pull
);
  always_ff @(posedge clk) begin
    if (rst) irq_pull <= 1'b0;
    else     irq_pull <= |stat_next;
  end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int N_PINS = 16,
  parameter int PORT_W = 8,
  localparam int N_PORTS = N_PINS / PORT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PINS-1:0]  pin_lvl,
  input  logic [N_PINS-1:0]  capture_en,
  input  logic [N_PINS-1:0]  invert,
  input  logic [N_PINS-1:0]  dir_in,
  input  logic [N_PINS-1:0]  irq_mask,
  input  logic [N_PORTS-1:0] rd_clr,
  output logic [N_PINS-1:0]  rd_data,
  output logic [N_PINS-1:0]  irq_status,
  output logic               irq_pull
);
  logic [N_PINS-1:0] stat_next;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    pin_change_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .live      (pin_lvl[i]),
      .capture   (capture_en[i]),
      .inv       (invert[i]),
      .is_input  (dir_in[i]),
      .masked    (irq_mask[i]),
      .rd_strobe (rd_clr[i / PORT_W]),
      .rd_bit    (rd_data[i]),
      .stat_bit  (irq_status[i]),
      .stat_next (stat_next[i])
    );
  end

  irq_combine #(.N_PINS(N_PINS)) u_comb (
    .clk       (clk),
    .rst       (rst),
    .stat_next (stat_next),
    .irq_pull  (irq_pull)
  );
endmodule

// File: rtl/pin_change_chk.sv
module pin_change_chk #(
  parameter int N_PINS = 16,
  parameter int PORT_W = 8,
  localparam int N_PORTS = N_PINS / PORT_W
) (
  input logic               clk,
  input logic               rst,
  input logic [N_PINS-1:0]  dir_in,
  input logic [N_PINS-1:0]  irq_mask,
  input logic [N_PORTS-1:0] rd_clr,
  input logic [N_PINS-1:0]  irq_status,
  input logic               irq_pull
);
  // R1: reset clears status and the pull enable
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (irq_status == '0 && !irq_pull));

  // R5: pull enable mirrors the OR of status bits
  a_r5_pull_matches_status: assert property (@(posedge clk) disable iff (rst)
    irq_pull == (irq_status != '0));

  // R6: masked pins report no status
  a_r6_masked_silent: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((irq_status & $past(irq_mask)) == '0));

  // R7: output pins report no status
  a_r7_output_silent: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((irq_status & ~$past(dir_in)) == '0));

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    // R4: a port read clears the status of that port
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
      rd_clr[p] |=> (irq_status[p*PORT_W +: PORT_W] == '0));
  end
endmodule

bind pin_change_irq pin_change_chk #(.N_PINS(N_PINS), .PORT_W(PORT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dir_in     (dir_in),
  .irq_mask   (irq_mask),
  .rd_clr     (rd_clr),
  .irq_status (irq_status),
  .irq_pull   (irq_pull)
);

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
  localparam int N = 16;
  localparam int PW = 8;
  localparam int NP = N / PW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic [N-1:0]  pin_lvl, capture_en, invert, dir_in, irq_mask;
  logic [NP-1:0] rd_clr;
  logic [N-1:0]  rd_data, irq_status;
  logic          irq_pull;

  pin_change_irq #(.N_PINS(N), .PORT_W(PW)) u_pin_change_irq (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .capture_en(capture_en),
    .invert(invert), .dir_in(dir_in), .irq_mask(irq_mask), .rd_clr(rd_clr),
    .rd_data(rd_data), .irq_status(irq_status), .irq_pull(irq_pull)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [N-1:0] m_ref, m_pend, m_cap, e_rd, e_st;
  logic         e_irq;

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model from the requirements; computes values visible after the next edge.
  task automatic model_edge();
    for (int i = 0; i < N; i++) begin
      logic lv, rd;
      lv = pin_lvl[i];
      rd = rd_clr[i / PW];
      if (rst || !dir_in[i] || rd) begin
        m_ref[i] = lv; m_pend[i] = 1'b0; m_cap[i] = lv;
      end else if (capture_en[i]) begin
        if (!m_pend[i]) begin m_cap[i] = lv; m_pend[i] = (lv != m_ref[i]); end
      end else begin
        m_cap[i] = lv; m_pend[i] = (lv != m_ref[i]);
      end
      e_rd[i] = ((!rst && capture_en[i] && m_pend[i]) ? m_cap[i] : lv) ^ invert[i];
      e_st[i] = rst ? 1'b0 : (m_pend[i] & ~irq_mask[i]);
    end
    e_irq = (e_st != '0);
  endtask

  // Inputs are set by the caller; one edge; outputs compared at the negedge.
  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check("R3/R9 rd_data", rd_data, e_rd);
    check("R6 irq_status", irq_status, e_st);
    check("R5 irq_pull", {{(N-1){1'b0}}, irq_pull}, {{(N-1){1'b0}}, e_irq});
    rd_clr = '0;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    rst = 1'b1; pin_lvl = 16'h5a0f; capture_en = '0; invert = '0;
    dir_in = '1; irq_mask = '1; rd_clr = '0;
    m_ref = '0; m_pend = '0; m_cap = '0;
    @(negedge clk);
    step(); step();
    // R1: reset state
    check("R1 status after reset", irq_status, '0);
    check("R1 pull after reset", {15'b0, irq_pull}, 16'h0);
    check("R1 rd_data after reset", rd_data, 16'h5a0f);
    rst = 1'b0; irq_mask = '0; pin_lvl = '0; step();
    rd_clr = '1; step(); step();

    // R2: follow mode sets and self-clears
    pin_lvl[4] = 1'b1; step();
    check("R2 follow pending", irq_status, 16'h0010);
    check("R5 pull on", {15'b0, irq_pull}, 16'h1);
    pin_lvl[4] = 1'b0; step();
    check("R2 follow self-clear", irq_status, 16'h0000);

    // R3 and R4: capture mode pulse 0-1-0, read twice
    capture_en[4] = 1'b1; step();
    pin_lvl[4] = 1'b1; step();
    pin_lvl[4] = 1'b0; step();
    check("R3 capture holds value", rd_data & 16'h0010, 16'h0010);
    check("R3 capture holds pending", irq_status, 16'h0010);
    rd_clr = 2'b10; step();
    check("R4 other port read leaves pin", irq_status, 16'h0010);
    rd_clr = 2'b01; step();
    check("R4 read clears pending", irq_status, 16'h0000);
    check("R4 next read is live", rd_data & 16'h0010, 16'h0000);

    // R6: mask then unmask a pending captured pin
    irq_mask[4] = 1'b1; pin_lvl[4] = 1'b1; step();
    pin_lvl[4] = 1'b0; step();
    check("R6 masked silent", {15'b0, irq_pull}, 16'h0);
    irq_mask[4] = 1'b0; step();
    check("R6 unmask asserts", irq_status, 16'h0010);
    irq_mask[4] = 1'b1; step();
    check("R6 mask deasserts", {15'b0, irq_pull}, 16'h0);
    irq_mask[4] = 1'b0; step();

    // R8: captured pending pin back at reference switched to follow mode
    capture_en[4] = 1'b0; step();
    check("R8 switch clears", irq_status, 16'h0000);
    check("R8 live value", rd_data & 16'h0010, 16'h0000);

    // R7: output direction clears and suppresses
    capture_en[4] = 1'b1; pin_lvl[4] = 1'b1; step();
    dir_in[4] = 1'b0; pin_lvl[4] = 1'b0; step();
    check("R7 output clears pending", irq_status, 16'h0000);
    pin_lvl[4] = 1'b1; step();
    check("R7 output no interrupt", irq_status, 16'h0000);
    check("R7 output reports level", rd_data & 16'h0010, 16'h0010);
    dir_in[4] = 1'b1; step();

    // R9: polarity
    invert[4] = 1'b1; step();
    check("R9 inverted read", rd_data & 16'h0010, 16'h0000);
    invert = '0; capture_en = '0; rd_clr = '1; step();

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 9) == 0) pin_lvl[i] = ~pin_lvl[i];
      if ($urandom_range(0, 7) == 0) rd_clr = 2'($urandom);
      if ($urandom_range(0, 19) == 0) capture_en ^= 16'(1 << $urandom_range(0, N-1));
      if ($urandom_range(0, 19) == 0) irq_mask  ^= 16'(1 << $urandom_range(0, N-1));
      if ($urandom_range(0, 29) == 0) dir_in    ^= 16'(1 << $urandom_range(0, N-1));
      if ($urandom_range(0, 39) == 0) invert    ^= 16'(1 << $urandom_range(0, N-1));
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule